// File: doc/BRIEF.md
# Condition Watch: Status-Change Monitor with Interrupt Flags

The block keeps one status bit for each of three conditions: the oscillator is running and qualified, the supply is low, and the die is hot. Each status bit has a sticky flag. The flag is raised whenever its status bit toggles, on a rise and on a fall alike. Each flag has an enable bit, and the block drives a single registered interrupt line from the enabled flags.

Four digital comparator results come from the analog side:
- supply under its trip level;
- supply over its release level;
- temperature over its trip level;
- temperature under its release level.

These four inputs are asynchronous and each passes through a two-flop synchronizer. Each of the voltage and temperature sources is a two-state machine, HY_CLEAR and HY_ALARM:
- HY_CLEAR goes to HY_ALARM on the trip input.
- HY_ALARM goes back to HY_CLEAR on the release input.
- Both transitions happen only while full performance mode is indicated. In any other mode the state holds.

The oscillator source is a two-state machine, OSC_DOWN and OSC_UP:
- OSC_DOWN goes to OSC_UP when the oscillator is qualified, the PLL is locked, and no kill condition is present.
- OSC_UP goes back to OSC_DOWN on any kill condition: PLL lock loss, a PLL reconfiguration pulse, full stop, oscillator disable, or loss of qualification.

Software reaches the block through a small register port. It can read the status bits, clear flags by writing ones, and read or write the enables.

Top module: `cond_watch`

## Requirements
- R1: While reset is low, and right after it, the status bits, flags and enables read 0 and `irq_o` is 0.
- R2: The low-voltage status (status bit 1) behaves as follows while `fpm_i` is 1:
  - It becomes 1 when the synchronized supply-under input is 1.
  - Once it is 1, it returns to 0 only when the synchronized supply-over input is 1.
  - When neither input calls for a change, it keeps its value.
- R3: The high-temperature status (status bit 2) behaves as follows while `fpm_i` is 1:
  - It becomes 1 when the synchronized temperature-over input is 1.
  - Once it is 1, it returns to 0 only when the synchronized temperature-under input is 1.
- R4: The oscillator status (status bit 0) behaves as follows:
  - It becomes 1 on the clock edge where `osc_ok_i` and `pll_lock_i` are both 1 and none of `pll_cfg_chg_i`, `full_stop_i` or `osc_off_i` is 1.
  - It drops to 0 on the edge after any of those kill conditions, or after `osc_ok_i` goes to 0.
- R5: A flag becomes 1 on the same edge on which its status bit changes, whether the bit rises or falls.
- R6: Writing to address 1 clears each flag whose data bit is 1.
  - A data bit of 0 leaves its flag unchanged.
  - If a flag's status changes on the same edge as its clear, the flag stays 1.
- R7: While `fpm_i` is 0, the low-voltage and high-temperature status bits hold their value whatever the comparator inputs do.
- R8: `irq_o` is registered. It is 1 one edge after any flag and its matching enable are both 1, and 0 otherwise.
- R9: The register map is as follows. Bit i of each register belongs to source i (0 oscillator, 1 low voltage, 2 high temperature).

  | Address | Access | Contents |
  |---|---|---|
  | 0 | read only; writes are ignored | status bits |
  | 1 | read; write 1 to clear | flags |
  | 2 | read and write | enables |
  | 3 | read | reads 0 |

  The read data is combinational from `reg_addr_i`.
- R10: A comparator input change reaches the status bit on the third rising edge after it is applied, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fpm_i | input | 1 | Full performance mode indication |
| sup_below_i | input | 1 | Supply under trip level (asynchronous) |
| sup_above_i | input | 1 | Supply over release level (asynchronous) |
| tmp_above_i | input | 1 | Temperature over trip level (asynchronous) |
| tmp_below_i | input | 1 | Temperature under release level (asynchronous) |
| osc_ok_i | input | 1 | Oscillator qualified |
| pll_lock_i | input | 1 | PLL locked |
| pll_cfg_chg_i | input | 1 | PLL configuration change pulse |
| full_stop_i | input | 1 | Full stop mode active |
| osc_off_i | input | 1 | Oscillator disabled |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 3 | Register write data |
| reg_rdata_o | output | 3 | Register read data |
| irq_o | output | 1 | Interrupt request |

## Verification
Results arrive at fixed distances from their stimulus:

| Stimulus | Result | Due |
|---|---|---|
| Comparator input | Status bit and flag | Third rising edge |
| Oscillator-side input | Status bit and flag | First rising edge |
| Register write | Flag or enable | Edge of the write |
| Flag or enable change | `irq_o` | One edge later |

The bench drives every input at a falling edge. It reads status and flags only at falling edges. Directed tests sample exactly on the due edge, and on the edge before it where the result must not yet have appeared. The vector walk waits four edges, so that every status has settled before it checks the status and the flags.

// File: rtl/cw_pkg.sv
`timescale 1ns/1ps
package cw_pkg;
    localparam int SRC_N       = 3;
    localparam int CMP_N       = 4;
    localparam int ADDR_W      = 2;
    localparam int SYNC_STAGES = 2;
    localparam int HY_N        = SRC_N - 1;

    localparam int SRC_OSC = 0;
    localparam int SRC_LV  = 1;
    localparam int SRC_HT  = 2;

    localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] A_FLAG = 2'd1;
    localparam logic [ADDR_W-1:0] A_EN   = 2'd2;

    typedef enum logic {HY_CLEAR, HY_ALARM} hy_state_t;
    typedef enum logic {OSC_DOWN, OSC_UP} osc_state_t;
endpackage

// File: rtl/cw_sync.sv
`timescale 1ns/1ps
module cw_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cw_hyst.sv
`timescale 1ns/1ps
module cw_hyst
    import cw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic trip_i,
    input  logic rel_i,
    output logic status_o,
    output logic change_o
);
    hy_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HY_CLEAR;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HY_CLEAR: if (active_i && trip_i) st_d = HY_ALARM;
            HY_ALARM: if (active_i && rel_i)  st_d = HY_CLEAR;
            default:  st_d = HY_CLEAR;
        endcase
    end

    always_comb begin
        status_o = (st_q == HY_ALARM);
        change_o = (st_d != st_q);
    end

    // R7: outside full performance mode the state does not move
    a_r7_hold_outside_fpm: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> $stable(status_o));

    // R2 and R3: an alarm is left only through the release input
    a_r2_alarm_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !rel_i) |=> status_o);

    // R3: a clear state is left only through the trip input
    a_r3_clear_needs_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o && !trip_i) |=> !status_o);
endmodule

// File: rtl/cw_osc.sv
`timescale 1ns/1ps
module cw_osc
    import cw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic osc_ok_i,
    input  logic pll_lock_i,
    input  logic pll_cfg_chg_i,
    input  logic full_stop_i,
    input  logic osc_off_i,
    output logic status_o,
    output logic change_o
);
    osc_state_t st_q, st_d;
    logic       kill;

    assign kill = !osc_ok_i || !pll_lock_i || pll_cfg_chg_i || full_stop_i || osc_off_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= OSC_DOWN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OSC_DOWN: if (!kill) st_d = OSC_UP;
            OSC_UP:   if (kill)  st_d = OSC_DOWN;
            default:  st_d = OSC_DOWN;
        endcase
    end

    always_comb begin
        status_o = (st_q == OSC_UP);
        change_o = (st_d != st_q);
    end

    // R4: lock loss, reconfiguration, full stop or disable force the status low
    a_r4_forced_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_lock_i || pll_cfg_chg_i || full_stop_i || osc_off_i) |=> !status_o);
endmodule

// File: rtl/cw_regs.sv
`timescale 1ns/1ps
module cw_regs
    import cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  status_i,
    input  logic [SRC_N-1:0]  change_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SRC_N-1:0]  wdata_i,
    output logic [SRC_N-1:0]  rdata_o,
    output logic              irq_o
);
    logic [SRC_N-1:0] flag_q, en_q, clr_mask;

    assign clr_mask = (wr_i && addr_i == A_FLAG) ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            en_q   <= '0;
            irq_o  <= 1'b0;
        end else begin
            flag_q <= (flag_q & ~clr_mask) | change_i;
            if (wr_i && addr_i == A_EN) en_q <= wdata_i;
            irq_o  <= |(flag_q & en_q);
        end
    end

    always_comb begin
        unique case (addr_i)
            A_STAT:  rdata_o = status_i;
            A_FLAG:  rdata_o = flag_q;
            A_EN:    rdata_o = en_q;
            default: rdata_o = '0;
        endcase
    end

    // R5: a status change always leaves its flag set
    a_r5_flag_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (change_i != '0) |=> ((flag_q & $past(change_i)) == $past(change_i)));

    // R6: a clear without a coincident change empties the flag
    a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_mask & ~change_i) != '0) |=> ((flag_q & $past(clr_mask & ~change_i)) == '0));

    // R8: the interrupt follows the enabled flags one edge later
    a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & en_q) != '0) |=> irq_o);
endmodule

// File: rtl/cond_watch.sv
`timescale 1ns/1ps
module cond_watch
    import cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fpm_i,
    input  logic              sup_below_i,
    input  logic              sup_above_i,
    input  logic              tmp_above_i,
    input  logic              tmp_below_i,
    input  logic              osc_ok_i,
    input  logic              pll_lock_i,
    input  logic              pll_cfg_chg_i,
    input  logic              full_stop_i,
    input  logic              osc_off_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [SRC_N-1:0]  reg_wdata_i,
    output logic [SRC_N-1:0]  reg_rdata_o,
    output logic              irq_o
);
    logic [CMP_N-1:0] cmp_s;
    logic [SRC_N-1:0] status, change;
    logic [HY_N-1:0]  trip_v, rel_v;

    cw_sync #(.W(CMP_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({tmp_below_i, tmp_above_i, sup_above_i, sup_below_i}),
        .q_o   (cmp_s)
    );

    // index 0 is supply, index 1 is temperature
    assign trip_v = {cmp_s[2], cmp_s[0]};
    assign rel_v  = {cmp_s[3], cmp_s[1]};

    for (genvar g = 0; g < HY_N; g++) begin : g_hyst
        cw_hyst u_hyst (
            .clk      (clk),
            .rst_n    (rst_n),
            .active_i (fpm_i),
            .trip_i   (trip_v[g]),
            .rel_i    (rel_v[g]),
            .status_o (status[SRC_LV+g]),
            .change_o (change[SRC_LV+g])
        );
    end

    cw_osc u_osc (
        .clk           (clk),
        .rst_n         (rst_n),
        .osc_ok_i      (osc_ok_i),
        .pll_lock_i    (pll_lock_i),
        .pll_cfg_chg_i (pll_cfg_chg_i),
        .full_stop_i   (full_stop_i),
        .osc_off_i     (osc_off_i),
        .status_o      (status[SRC_OSC]),
        .change_o      (change[SRC_OSC])
    );

    cw_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status),
        .change_i (change),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .rdata_o  (reg_rdata_o),
        .irq_o    (irq_o)
    );

    // R1: nothing is pending straight out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> !irq_o);
endmodule

// File: tb/cond_watch_tb.sv
`timescale 1ns/1ps
module cond_watch_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fpm = 0, vb = 0, va = 0, ta = 0, tb = 0;
    logic       ok = 0, lock = 0, cfg = 0, fstop = 0, ooff = 0;
    logic       wr = 0;
    logic [1:0] addr = 0;
    logic [2:0] wdata = 0;
    logic [2:0] rdata;
    logic       irq;

    int  n_run = 0, n_fail = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    cond_watch dut_i (
        .clk(clk), .rst_n(rst_n), .fpm_i(fpm),
        .sup_below_i(vb), .sup_above_i(va), .tmp_above_i(ta), .tmp_below_i(tb),
        .osc_ok_i(ok), .pll_lock_i(lock), .pll_cfg_chg_i(cfg),
        .full_stop_i(fstop), .osc_off_i(ooff),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    // fields: [9] fpm [8] sup_below [7] sup_above [6] tmp_above [5] tmp_below
    //         [4] osc_ok [3] pll_lock [2:0] expected status {ht, lv, osc}
    localparam logic [9:0] VEC [12] = '{
        10'b1_0000_11_001, 10'b1_1000_11_011, 10'b1_0000_11_011,
        10'b1_0100_11_001, 10'b1_0110_11_101, 10'b1_0100_11_101,
        10'b1_0101_11_001, 10'b0_1010_11_001, 10'b1_1010_11_111,
        10'b1_1010_10_110, 10'b0_0101_11_111, 10'b1_0101_11_001
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [2:0] v);
        wr = 0;
        addr = a;
        #0.5;
        v = rdata;
    endtask

    task automatic wrr(input logic [1:0] a, input logic [2:0] d);
        wr = 1;
        addr = a;
        wdata = d;
        tick();
        wr = 0;
    endtask

    initial begin
        logic [2:0] v, prev;
        // R1 reset values
        repeat (2) tick();
        rd(2'd0, v); chk("R1 status in reset", {5'd0, v}, 8'd0);
        rd(2'd1, v); chk("R1 flags in reset", {5'd0, v}, 8'd0);
        rd(2'd2, v); chk("R1 enables in reset", {5'd0, v}, 8'd0);
        chk("R1 irq in reset", {7'd0, irq}, 8'd0);
        rst_n = 1;
        tick();
        rd(2'd0, v); chk("R1 status after reset", {5'd0, v}, 8'd0);

        prev = 3'b000;
        for (int i = 0; i < 12; i++) begin
            {fpm, vb, va, ta, tb, ok, lock} = VEC[i][9:3];
            repeat (4) tick();
            // R2 R3 R4 R7 status, R5 flags on either edge
            rd(2'd0, v); chk($sformatf("R2 R3 R4 R7 status vec %0d", i), {5'd0, v}, {5'd0, VEC[i][2:0]});
            rd(2'd1, v); chk($sformatf("R5 flags vec %0d", i), {5'd0, v}, {5'd0, VEC[i][2:0] ^ prev});
            chk($sformatf("R8 irq masked vec %0d", i), {7'd0, irq}, 8'd0);
            wrr(2'd1, 3'b111);
            prev = VEC[i][2:0];
        end
        // now: fpm=1 va=1 tb=1 ok=1 lock=1, status 001, flags 0

        // R10 two-flop latency
        vb = 1; va = 0;
        tick(); tick();
        rd(2'd0, v); chk("R10 status after two edges", {5'd0, v}, 8'h1);
        tick();
        rd(2'd0, v); chk("R10 status on third edge", {5'd0, v}, 8'h3);
        rd(2'd1, v); chk("R10 flag on third edge", {5'd0, v}, 8'h2);

        // R8 interrupt timing
        wrr(2'd2, 3'b010);
        chk("R8 irq on enable edge", {7'd0, irq}, 8'd0);
        tick();
        chk("R8 irq one edge later", {7'd0, irq}, 8'd1);
        wrr(2'd1, 3'b000);
        rd(2'd1, v); chk("R6 write 0 keeps flag", {5'd0, v}, 8'h2);
        wrr(2'd1, 3'b010);
        rd(2'd1, v); chk("R6 write 1 clears flag", {5'd0, v}, 8'h0);
        tick();
        chk("R8 irq drops after clear", {7'd0, irq}, 8'd0);

        // R6 clear and change on the same edge
        ooff = 1;
        wrr(2'd1, 3'b001);
        rd(2'd0, v); chk("R4 osc off drops status", {5'd0, v}, 8'h2);
        rd(2'd1, v); chk("R6 change beats clear", {5'd0, v}, 8'h1);
        wrr(2'd1, 3'b001);
        ooff = 0;
        tick();
        rd(2'd0, v); chk("R4 osc back up", {5'd0, v}, 8'h3);
        wrr(2'd1, 3'b111);

        // R4 reconfiguration pulse and full stop
        cfg = 1; tick(); cfg = 0;
        rd(2'd0, v); chk("R4 cfg pulse drops osc", {5'd0, v}, 8'h2);
        rd(2'd1, v); chk("R4 cfg pulse sets flag", {5'd0, v}, 8'h1);
        tick();
        rd(2'd0, v); chk("R4 osc returns after pulse", {5'd0, v}, 8'h3);
        wrr(2'd1, 3'b111);
        fstop = 1; tick();
        rd(2'd0, v); chk("R4 full stop drops osc", {5'd0, v}, 8'h2);
        rd(2'd1, v); chk("R4 full stop sets flag", {5'd0, v}, 8'h1);
        fstop = 0; tick();
        wrr(2'd1, 3'b111);

        // R9 map
        wrr(2'd2, 3'b101);
        rd(2'd2, v); chk("R9 enable readback", {5'd0, v}, 8'h5);
        rd(2'd3, v); chk("R9 unused address", {5'd0, v}, 8'h0);
        wrr(2'd0, 3'b000);
        rd(2'd0, v); chk("R9 status ignores write", {5'd0, v}, 8'h3);

        // R1 reset mid-run
        rst_n = 0;
        tick();
        rd(2'd0, v); chk("R1 status after mid reset", {5'd0, v}, 8'h0);
        rd(2'd2, v); chk("R1 enables after mid reset", {5'd0, v}, 8'h0);
        chk("R1 irq after mid reset", {7'd0, irq}, 8'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule